// File: doc/BRIEF.md
# Memory Dependence Wakeup Tracker

This block keeps track of the memory operations one thread of an out-of-order core has in flight: loads, stores, full memory barriers and write barriers. Each operation takes one slot of a small table and is named by its sequence number. When an operation is inserted, the block decides which older operation it must wait for. That producer is the active barrier when one applies. Otherwise it is the store that an external dependence predictor names on `ins_pred_seq`. If the producer is still held in the table, the new entry is linked to it by slot index.

A load or store is released only when it is both register-ready and memory-dependence-ready. A released entry's sequence number joins a small output FIFO, where the issue logic collects it with a valid/ready handshake. When a store or barrier completes, all of its linked dependents are woken in one cycle by a parallel compare. Completion also frees the completing entry's slot.

The block has three further operations:
- A squash removes every entry younger than a given sequence number.
- Rescheduled entries are parked. A replay command sends all of them out again.
- Non-speculative entries wait for an explicit go command.

Top module: `memdep_tracker`

## Requirements
- R1: The block takes at most one command per cycle from insert, register-ready, go, completion, reschedule, replay and squash. An insert counts only when `ins_valid` and `ins_ready` are both high. `ins_ready` is low whenever all ENTRIES slots are occupied.
- R2: `ins_kind` encodes the operation type: 0 is a load, 1 a store, 2 a full memory barrier and 3 a write barrier. A load inserted while the load barrier is active takes the load barrier's sequence number as its producer. A store inserted while the store barrier is active takes the store barrier's number. In every other case the producer is `ins_pred_seq`.
- R3: An entry becomes memory-dependence-ready at insert if any of these holds: its producer is 0, the producer is not held in the table, or the held producer is a load. If `ins_regs_ok` is also high, the entry's sequence number appears on the output without any further command.
- R4: A full barrier arms both barrier flags with its own sequence number. A write barrier arms only the store flag. Barrier entries never appear on the output.
- R5: When a barrier completes, each flag it arms is disarmed only if that flag still records the completing barrier's sequence number. A younger barrier keeps the flag armed.
- R6: Completion of a store or barrier releases every linked dependent whose registers are ready. A linked dependent whose registers are not ready is only marked memory-dependence-ready. Any completion frees the entry's slot.
- R7: A register-ready notification releases an entry only if the entry is already memory-dependence-ready. Otherwise the entry keeps waiting.
- R8: An entry inserted with `ins_nonspec` high is never linked and is released only by a go command naming it. A register-ready notification does not release it.
- R9: A squash with number S removes every entry whose sequence number is greater than S. Later commands that name a removed entry have no effect. A squash with S = 0 empties the table.
- R10: A reschedule command parks an entry. A replay command releases every parked entry once. A parked entry removed by a squash is not released.
- R11: The output FIFO holds OUT_DEPTH sequence numbers. While `out_valid` is high and `out_ready` is low, `out_seq` stays stable. A released entry that finds the FIFO full waits and is not lost.
- R12: When several entries are released at the same time, they enter the FIFO one per cycle, oldest (smallest sequence number) first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ins_valid | input | 1 | Insert request |
| ins_ready | output | 1 | A free slot is available |
| ins_seq | input | SEQ_W | Sequence number of the inserted operation |
| ins_kind | input | 2 | 0 load, 1 store, 2 full barrier, 3 write barrier |
| ins_nonspec | input | 1 | Insert as non-speculative |
| ins_regs_ok | input | 1 | Source registers already ready at insert |
| ins_pred_seq | input | SEQ_W | Predicted producing store, 0 for none |
| rr_valid | input | 1 | Register-ready notification |
| rr_seq | input | SEQ_W | Entry named by the notification |
| go_valid | input | 1 | Non-speculative go command |
| go_seq | input | SEQ_W | Entry named by the go command |
| done_valid | input | 1 | Completion command |
| done_seq | input | SEQ_W | Completing entry |
| resched_valid | input | 1 | Reschedule command |
| resched_seq | input | SEQ_W | Entry to park for replay |
| replay_go | input | 1 | Release all parked entries |
| sq_valid | input | 1 | Squash command |
| sq_seq | input | SEQ_W | Youngest sequence number that survives |
| out_valid | output | 1 | Output FIFO holds a ready entry |
| out_ready | input | 1 | Consumer takes the head entry |
| out_seq | output | SEQ_W | Sequence number of the head entry |

## Verification
The assertions assume four things about the inputs:
- At most one command arrives per cycle.
- Sequence numbers are nonzero and strictly increasing, and they do not wrap while entries are held.
- Register-ready, go, completion and reschedule commands name entries that were inserted.
- The consumer drives `out_ready` only as a handshake against `out_valid`.

The bench keeps to these rules in two ways. Every command is issued by a task that raises exactly one command signal for exactly one clock. Each scenario draws fresh, increasing sequence numbers and ends with a squash to 0, so no entry carries over into the next scenario.

// File: rtl/memdep_pkg.sv
package memdep_pkg;

  typedef enum logic [1:0] {
    K_LOAD  = 2'd0,
    K_STORE = 2'd1,
    K_MBAR  = 2'd2,
    K_WBAR  = 2'd3
  } kind_e;

endpackage

// File: rtl/memdep_pick_free.sv
module memdep_pick_free #(
  parameter int N = 16
) (
  input  logic [N-1:0]         busy,
  output logic                 any_free,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IW = $clog2(N);

  always_comb begin
    any_free = 1'b0;
    idx      = '0;
    for (int i = 0; i < N; i++) begin
      if (!busy[i] && !any_free) begin
        any_free = 1'b1;
        idx      = IW'(i);
      end
    end
  end
endmodule

// File: rtl/memdep_cam.sv
module memdep_cam #(
  parameter int N  = 16,
  parameter int SW = 16
) (
  input  logic [N-1:0]         valid,
  input  logic [N-1:0][SW-1:0] seqs,
  input  logic [SW-1:0]        key,
  output logic                 hit,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IW = $clog2(N);

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (valid[i] && (seqs[i] == key) && !hit) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/memdep_pick_oldest.sv
module memdep_pick_oldest #(
  parameter int N  = 16,
  parameter int SW = 16
) (
  input  logic [N-1:0]         req,
  input  logic [N-1:0][SW-1:0] seqs,
  output logic                 found,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IW = $clog2(N);

  logic [SW-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!found || (seqs[i] < best))) begin
        found = 1'b1;
        idx   = IW'(i);
        best  = seqs[i];
      end
    end
  end
endmodule

// File: rtl/memdep_ofifo.sv
module memdep_ofifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  output logic         valid,
  input  logic         pop,
  output logic [W-1:0] dout
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][W-1:0] mem_q;
  logic [PW-1:0]           wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]           cnt_q, cnt_d;
  logic                    pop_ok;

  assign full   = (cnt_q == CW'(DEPTH));
  assign valid  = (cnt_q != '0);
  assign dout   = mem_q[rp_q];
  assign pop_ok = pop && valid;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q + CW'(push) - CW'(pop_ok);
    if (push)   wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
    if (pop_ok) rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wp_q] <= din;
  end

  // R11: the producer side must never write into a full FIFO
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
endmodule

// File: rtl/memdep_tracker.sv
module memdep_tracker
  import memdep_pkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter int SEQ_W     = 16,
  parameter int OUT_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic [1:0]       ins_kind,
  input  logic             ins_nonspec,
  input  logic             ins_regs_ok,
  input  logic [SEQ_W-1:0] ins_pred_seq,
  input  logic             rr_valid,
  input  logic [SEQ_W-1:0] rr_seq,
  input  logic             go_valid,
  input  logic [SEQ_W-1:0] go_seq,
  input  logic             done_valid,
  input  logic [SEQ_W-1:0] done_seq,
  input  logic             resched_valid,
  input  logic [SEQ_W-1:0] resched_seq,
  input  logic             replay_go,
  input  logic             sq_valid,
  input  logic [SEQ_W-1:0] sq_seq,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SEQ_W-1:0] out_seq
);
  localparam int IW = $clog2(ENTRIES);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  // entry state
  logic [ENTRIES-1:0]            v_q, v_d;
  logic [ENTRIES-1:0]            regs_q, regs_d;
  logic [ENTRIES-1:0]            memok_q, memok_d;
  logic [ENTRIES-1:0]            pend_q, pend_d;
  logic [ENTRIES-1:0]            park_q, park_d;
  logic [ENTRIES-1:0]            lnk_q, lnk_d;
  logic [ENTRIES-1:0][IW-1:0]    lidx_q, lidx_d;
  logic [ENTRIES-1:0][SEQ_W-1:0] seq_q, seq_d;
  kind_e                         kind_q [ENTRIES];
  kind_e                         kind_d [ENTRIES];

  // barrier flags
  logic             ldb_q, ldb_d, stb_q, stb_d;
  logic [SEQ_W-1:0] ldb_seq_q, ldb_seq_d, stb_seq_q, stb_seq_d;

  // command decode
  kind_e            ik;
  logic             ins_fire, is_mem, link_ok;
  logic [SEQ_W-1:0] cmd_seq, prod_seq;
  logic             cmd_hit, p_hit, free_ok, sel_v, push, fifo_full;
  logic [IW-1:0]    cmd_idx, p_idx, free_idx, sel_idx;

  assign ik        = kind_e'(ins_kind);
  assign ins_ready = free_ok;
  assign ins_fire  = ins_valid && ins_ready;
  assign is_mem    = (ik == K_LOAD) || (ik == K_STORE);

  always_comb begin
    if (rr_valid)        cmd_seq = rr_seq;
    else if (go_valid)   cmd_seq = go_seq;
    else if (done_valid) cmd_seq = done_seq;
    else                 cmd_seq = resched_seq;
  end

  always_comb begin
    if ((ik == K_LOAD) && ldb_q)       prod_seq = ldb_seq_q;
    else if ((ik == K_STORE) && stb_q) prod_seq = stb_seq_q;
    else                               prod_seq = ins_pred_seq;
  end

  memdep_pick_free #(.N(ENTRIES)) u_free (
    .busy(v_q), .any_free(free_ok), .idx(free_idx));

  memdep_cam #(.N(ENTRIES), .SW(SEQ_W)) u_cam_cmd (
    .valid(v_q), .seqs(seq_q), .key(cmd_seq), .hit(cmd_hit), .idx(cmd_idx));

  memdep_cam #(.N(ENTRIES), .SW(SEQ_W)) u_cam_prod (
    .valid(v_q), .seqs(seq_q), .key(prod_seq), .hit(p_hit), .idx(p_idx));

  memdep_pick_oldest #(.N(ENTRIES), .SW(SEQ_W)) u_oldest (
    .req(pend_q), .seqs(seq_q), .found(sel_v), .idx(sel_idx));

  assign link_ok = is_mem && !ins_nonspec && (prod_seq != '0) && p_hit &&
                   (kind_q[p_idx] != K_LOAD);
  assign push    = sel_v && !fifo_full;

  memdep_ofifo #(.W(SEQ_W), .DEPTH(OUT_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_s), .push(push), .din(seq_q[sel_idx]),
    .full(fifo_full), .valid(out_valid), .pop(out_ready), .dout(out_seq));

  // next state
  always_comb begin
    v_d       = v_q;
    regs_d    = regs_q;
    memok_d   = memok_q;
    pend_d    = pend_q;
    park_d    = park_q;
    lnk_d     = lnk_q;
    lidx_d    = lidx_q;
    seq_d     = seq_q;
    kind_d    = kind_q;
    ldb_d     = ldb_q;
    stb_d     = stb_q;
    ldb_seq_d = ldb_seq_q;
    stb_seq_d = stb_seq_q;

    if (push) pend_d[sel_idx] = 1'b0;

    if (ins_fire) begin
      v_d[free_idx]     = 1'b1;
      seq_d[free_idx]   = ins_seq;
      kind_d[free_idx]  = ik;
      park_d[free_idx]  = 1'b0;
      regs_d[free_idx]  = is_mem && ins_regs_ok;
      lnk_d[free_idx]   = link_ok;
      lidx_d[free_idx]  = p_idx;
      memok_d[free_idx] = is_mem && !ins_nonspec && !link_ok;
      pend_d[free_idx]  = is_mem && !ins_nonspec && !link_ok && ins_regs_ok;
      if (ik == K_MBAR) begin
        ldb_d     = 1'b1;
        ldb_seq_d = ins_seq;
        stb_d     = 1'b1;
        stb_seq_d = ins_seq;
      end else if (ik == K_WBAR) begin
        stb_d     = 1'b1;
        stb_seq_d = ins_seq;
      end
    end

    if (rr_valid && cmd_hit) begin
      regs_d[cmd_idx] = 1'b1;
      if (memok_q[cmd_idx]) pend_d[cmd_idx] = 1'b1;
    end

    if (go_valid && cmd_hit) pend_d[cmd_idx] = 1'b1;

    if (resched_valid && cmd_hit) park_d[cmd_idx] = 1'b1;

    if (done_valid && cmd_hit) begin
      v_d[cmd_idx]    = 1'b0;
      pend_d[cmd_idx] = 1'b0;
      park_d[cmd_idx] = 1'b0;
      lnk_d[cmd_idx]  = 1'b0;
      if (kind_q[cmd_idx] != K_LOAD) begin
        for (int j = 0; j < ENTRIES; j++) begin
          if (v_q[j] && lnk_q[j] && (lidx_q[j] == cmd_idx)) begin
            lnk_d[j]   = 1'b0;
            memok_d[j] = 1'b1;
            if (regs_q[j]) pend_d[j] = 1'b1;
          end
        end
      end
      if (kind_q[cmd_idx] == K_MBAR) begin
        if (ldb_seq_q == done_seq) ldb_d = 1'b0;
        if (stb_seq_q == done_seq) stb_d = 1'b0;
      end else if (kind_q[cmd_idx] == K_WBAR) begin
        if (stb_seq_q == done_seq) stb_d = 1'b0;
      end
    end

    if (replay_go) begin
      for (int j = 0; j < ENTRIES; j++) begin
        if (park_q[j]) begin
          pend_d[j] = 1'b1;
          park_d[j] = 1'b0;
        end
      end
    end

    if (sq_valid) begin
      for (int j = 0; j < ENTRIES; j++) begin
        if (v_q[j] && (seq_q[j] > sq_seq)) begin
          v_d[j]    = 1'b0;
          pend_d[j] = 1'b0;
          park_d[j] = 1'b0;
          lnk_d[j]  = 1'b0;
        end
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      v_q       <= '0;
      regs_q    <= '0;
      memok_q   <= '0;
      pend_q    <= '0;
      park_q    <= '0;
      lnk_q     <= '0;
      ldb_q     <= 1'b0;
      stb_q     <= 1'b0;
      ldb_seq_q <= '0;
      stb_seq_q <= '0;
    end else begin
      v_q       <= v_d;
      regs_q    <= regs_d;
      memok_q   <= memok_d;
      pend_q    <= pend_d;
      park_q    <= park_d;
      lnk_q     <= lnk_d;
      ldb_q     <= ldb_d;
      stb_q     <= stb_d;
      ldb_seq_q <= ldb_seq_d;
      stb_seq_q <= stb_seq_d;
    end
  end

  // payload registers, qualified by v_q
  always_ff @(posedge clk) begin
    seq_q  <= seq_d;
    lidx_q <= lidx_d;
    kind_q <= kind_d;
  end

  // R1: one command per cycle (input rule)
  p_one_cmd_r1: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0({ins_valid, rr_valid, go_valid, done_valid, resched_valid,
              replay_go, sq_valid}));

  // R1: a full table refuses inserts
  p_full_refuse_r1: assert property (@(posedge clk) disable iff (!rst_s)
    ($countones(v_q) == ENTRIES) |-> !ins_ready);

  // R9: squashing to zero empties the table
  p_squash_all_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (sq_valid && (sq_seq == '0)) |=> (v_q == '0));

  // R11: a stalled output holds its value
  p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_s)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_seq)));

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    // R4: only loads and stores are ever released
    p_pend_memop_r4: assert property (@(posedge clk) disable iff (!rst_s)
      pend_q[g] |-> (kind_q[g] == K_LOAD || kind_q[g] == K_STORE));
    // R6: an entry still linked to a producer is not released
    p_linked_waits_r6: assert property (@(posedge clk) disable iff (!rst_s)
      (v_q[g] && lnk_q[g]) |-> !pend_q[g]);
  end
endmodule

// File: tb/sim_memdep_tracker.sv
module sim_memdep_tracker;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ins_valid = 1'b0, ins_nonspec = 1'b0, ins_regs_ok = 1'b0;
  logic          ins_ready;
  logic [SW-1:0] ins_seq = '0, ins_pred_seq = '0;
  logic [1:0]    ins_kind = 2'd0;
  logic          rr_valid = 1'b0, go_valid = 1'b0, done_valid = 1'b0;
  logic          resched_valid = 1'b0, replay_go = 1'b0, sq_valid = 1'b0;
  logic [SW-1:0] rr_seq = '0, go_seq = '0, done_seq = '0, resched_seq = '0, sq_seq = '0;
  logic          out_valid, out_ready = 1'b0;
  logic [SW-1:0] out_seq;

  int n_chk = 0;
  int n_fail = 0;

  localparam int OP_RR = 0, OP_GO = 1, OP_DONE = 2, OP_RES = 3, OP_REP = 4, OP_SQ = 5;

  always #10 clk = ~clk;

  memdep_tracker u0 (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_seq(ins_seq),
    .ins_kind(ins_kind), .ins_nonspec(ins_nonspec), .ins_regs_ok(ins_regs_ok),
    .ins_pred_seq(ins_pred_seq),
    .rr_valid(rr_valid), .rr_seq(rr_seq), .go_valid(go_valid), .go_seq(go_seq),
    .done_valid(done_valid), .done_seq(done_seq),
    .resched_valid(resched_valid), .resched_seq(resched_seq),
    .replay_go(replay_go), .sq_valid(sq_valid), .sq_seq(sq_seq),
    .out_valid(out_valid), .out_ready(out_ready), .out_seq(out_seq));

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ins(input int s, input int k, input int pred, input logic regs, input logic ns);
    @(negedge clk);
    ins_valid = 1'b1; ins_seq = SW'(s); ins_kind = 2'(k);
    ins_pred_seq = SW'(pred); ins_regs_ok = regs; ins_nonspec = ns;
    @(negedge clk);
    ins_valid = 1'b0; ins_nonspec = 1'b0; ins_regs_ok = 1'b0;
  endtask

  task automatic cmd(input int op, input int s);
    @(negedge clk);
    case (op)
      OP_RR:   begin rr_valid = 1'b1; rr_seq = SW'(s); end
      OP_GO:   begin go_valid = 1'b1; go_seq = SW'(s); end
      OP_DONE: begin done_valid = 1'b1; done_seq = SW'(s); end
      OP_RES:  begin resched_valid = 1'b1; resched_seq = SW'(s); end
      OP_REP:  replay_go = 1'b1;
      default: begin sq_valid = 1'b1; sq_seq = SW'(s); end
    endcase
    @(negedge clk);
    rr_valid = 1'b0; go_valid = 1'b0; done_valid = 1'b0;
    resched_valid = 1'b0; replay_go = 1'b0; sq_valid = 1'b0;
  endtask

  // wait for the head of the output, check it, then take it
  task automatic expect_out(input int s, input string tag);
    int waited = 0;
    while (!out_valid && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    check(out_valid && (out_seq == SW'(s)), tag, out_valid ? int'(out_seq) : -1, s);
    if (out_valid) begin
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
  endtask

  task automatic expect_none(input string tag);
    logic seen = 1'b0;
    int   val  = -1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (out_valid && !seen) begin
        seen = 1'b1;
        val  = int'(out_seq);
      end
    end
    check(!seen, tag, val, -1);
  endtask

  task automatic clean();
    cmd(OP_SQ, 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(!out_valid, "R11 reset out_valid", int'(out_valid), 0);
    check(ins_ready, "R1 reset ins_ready", int'(ins_ready), 1);
  endtask

  task automatic t_basic();
    ins(10, 0, 0, 1'b1, 1'b0);
    expect_out(10, "R3 free load released");
    ins(11, 0, 0, 1'b0, 1'b0);
    expect_none("R7 load waits for registers");
    cmd(OP_RR, 11);
    expect_out(11, "R7 register-ready releases");
    clean();
  endtask

  task automatic t_wake();
    ins(20, 1, 0, 1'b1, 1'b0);
    expect_out(20, "R3 store released");
    ins(21, 0, 20, 1'b1, 1'b0);
    expect_none("R6 linked load waits");
    cmd(OP_DONE, 20);
    expect_out(21, "R6 store completion wakes load");
    ins(22, 1, 0, 1'b0, 1'b0);
    ins(23, 0, 22, 1'b0, 1'b0);
    cmd(OP_DONE, 22);
    expect_none("R6 wake without registers");
    cmd(OP_RR, 23);
    expect_out(23, "R6 mem-ready then register-ready");
    ins(24, 0, 999, 1'b1, 1'b0);
    expect_out(24, "R3 producer not held");
    ins(25, 0, 0, 1'b0, 1'b0);
    ins(26, 0, 25, 1'b1, 1'b0);
    expect_out(26, "R3 producer is a load");
    clean();
  endtask

  task automatic t_barrier();
    ins(30, 2, 0, 1'b0, 1'b0);
    ins(31, 0, 0, 1'b1, 1'b0);
    ins(32, 1, 0, 1'b1, 1'b0);
    expect_none("R2 loads and stores behind full barrier");
    cmd(OP_DONE, 30);
    expect_out(31, "R12 oldest woken first");
    expect_out(32, "R4 store behind full barrier");
    ins(40, 3, 0, 1'b0, 1'b0);
    ins(41, 0, 0, 1'b1, 1'b0);
    expect_out(41, "R4 write barrier leaves loads free");
    ins(42, 1, 0, 1'b1, 1'b0);
    expect_none("R2 store behind write barrier");
    cmd(OP_DONE, 40);
    expect_out(42, "R6 write barrier completion");
    ins(50, 2, 0, 1'b0, 1'b0);
    ins(51, 2, 0, 1'b0, 1'b0);
    cmd(OP_DONE, 50);
    ins(52, 0, 0, 1'b1, 1'b0);
    expect_none("R5 younger barrier keeps flag");
    cmd(OP_DONE, 51);
    expect_out(52, "R5 matching barrier clears flag");
    ins(53, 0, 0, 1'b1, 1'b0);
    expect_out(53, "R5 flag cleared");
    clean();
  endtask

  task automatic t_nonspec();
    ins(60, 0, 0, 1'b1, 1'b1);
    expect_none("R8 nonspec waits");
    cmd(OP_RR, 60);
    expect_none("R8 register-ready ignored");
    cmd(OP_GO, 60);
    expect_out(60, "R8 go releases");
    clean();
  endtask

  task automatic t_squash();
    ins(70, 0, 0, 1'b0, 1'b0);
    ins(71, 0, 0, 1'b0, 1'b0);
    ins(72, 0, 0, 1'b0, 1'b0);
    cmd(OP_SQ, 70);
    cmd(OP_RR, 71);
    cmd(OP_RR, 72);
    expect_none("R9 squashed entries gone");
    cmd(OP_RR, 70);
    expect_out(70, "R9 older entry survives");
    ins(80, 1, 0, 1'b0, 1'b0);
    ins(81, 0, 80, 1'b1, 1'b0);
    cmd(OP_SQ, 80);
    cmd(OP_DONE, 80);
    expect_none("R9 wakeup skips squashed");
    clean();
  endtask

  task automatic t_replay();
    ins(90, 0, 0, 1'b1, 1'b0);
    expect_out(90, "R3 load 90");
    ins(91, 0, 0, 1'b1, 1'b0);
    expect_out(91, "R3 load 91");
    cmd(OP_RES, 91);
    cmd(OP_RES, 90);
    expect_none("R10 parked entries wait");
    cmd(OP_REP, 0);
    expect_out(90, "R10 replay oldest first");
    expect_out(91, "R10 replay second");
    expect_none("R10 replayed once");
    ins(92, 0, 0, 1'b1, 1'b0);
    expect_out(92, "R3 load 92");
    cmd(OP_RES, 92);
    cmd(OP_SQ, 91);
    cmd(OP_REP, 0);
    expect_none("R10 squash drops parked entry");
    clean();
  endtask

  task automatic t_full();
    for (int i = 0; i < 16; i++) ins(100 + i, 0, 0, 1'b0, 1'b1);
    check(!ins_ready, "R1 full table refuses", int'(ins_ready), 0);
    cmd(OP_DONE, 105);
    check(ins_ready, "R6 completion frees slot", int'(ins_ready), 1);
    cmd(OP_SQ, 0);
    check(ins_ready, "R9 squash to zero empties", int'(ins_ready), 1);
    cmd(OP_GO, 100);
    expect_none("R9 removed entry ignores go");
    clean();
  endtask

  task automatic t_fifo();
    for (int i = 0; i < 6; i++) ins(120 + i, 0, 0, 1'b1, 1'b0);
    repeat (8) @(negedge clk);
    check(out_valid && out_seq == SW'(120), "R11 head held while stalled",
          int'(out_seq), 120);
    for (int i = 0; i < 6; i++) expect_out(120 + i, "R11 no entry lost");
    expect_none("R11 fifo drained");
    clean();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_wake();
    t_barrier();
    t_nonspec();
    t_squash();
    t_replay();
    t_full();
    t_fifo();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule